// File: doc/BRIEF.md
# Indexed Configuration Space with Memory-Bus Bridge

This block is the target side of a legacy-style configuration space reached through two byte-wide host I/O ports: an index port that selects a register number and a data port that reads or writes that register. The space stays locked after reset until the host writes a two-byte password to the index port. Once it is open, a global select register picks a logical device. Each device owns an enable bit and a small bank of base-address bytes. A few global scratch bytes let software confirm that the index/data path works.

One logical device is a bridge to a 32-bit memory-mapped bus. The host fills a 4-byte address window and a 4-byte data window one byte at a time. A read of the trigger register starts a bus read, and a write of a magic value to the trigger register starts a bus write. The transaction goes out on a request/ready master port. The returned read word lands in the data window, where the host can collect it afterwards. A busy flag protects the windows while a transaction is outstanding.

Top module: `cfgspace_bridge`

## Requirements
- R1: After reset the space is locked, `io_rdata` reads 0xFF, `m_req` is low, the selected device is 0 and every device enable reads 0.
- R2: Two consecutive writes of 0xA5 to the index port (0x2E) unlock the space. Any other index write in between restarts the count. While the space is locked, data port (0x2F) reads return 0xFF and writes change nothing.
- R3: Writing 0xAA to the index port while the space is open locks it again. The selected device persists across a lock and unlock.
- R4: Global registers 0x21 and 0x22 are plain read/write bytes.
- R5: Global register 0x07 selects the logical device. Later device-register accesses go to that device's bank until 0x07 is written again.
- R6: Register 0x30 of each device is its enable: bit 0 is stored, and it reads back as {7'b0, bit0}. Registers 0x60 to 0x66 are per-device bytes that read back what was written, independently for each device.
- R7: In device 0x0D, registers 0xF0 to 0xF3 form the bus address and 0xF4 to 0xF7 form the data word, most significant byte at the lowest register. Register 0xF8 is a read/write length byte.
- R8: In device 0x0D, a data read of register 0xFE while idle starts a bus read (`m_req`=1, `m_we`=0) at the assembled address. That read returns 0x00. The same read while busy returns 0x01 and starts nothing.
- R9: `m_req` and its address, data and direction stay stable until `m_ready`, and drop the cycle after the handshake. A completed read writes `m_rdata` into 0xF4 to 0xF7.
- R10: In device 0x0D, writing 0xCF to 0xFE while idle starts a bus write (`m_we`=1) of the data window to the address window. Any other value starts nothing.
- R11: While busy, writes to 0xF0 to 0xF8 and further triggers are ignored, and window reads return the held contents.
- R12: Register 0xFE and the bridge windows have no effect in any other device. Unmapped registers read 0x00.
- R13: Read data appears on `io_rdata` in the cycle after the read strobe and holds until the next decoded read. Strobes to other I/O addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | Host I/O address |
| io_rd | input | 1 | Host read strobe, one cycle |
| io_wr | input | 1 | Host write strobe, one cycle |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Host read byte, valid the cycle after `io_rd` |
| m_req | output | 1 | Bus request, held until `m_ready` |
| m_we | output | 1 | Bus direction, 1 for write |
| m_addr | output | 32 | Bus address |
| m_wdata | output | 32 | Bus write word |
| m_ready | input | 1 | Bus completion handshake |
| m_rdata | input | 32 | Bus read word, sampled on handshake |
| bridge_busy | output | 1 | Bridge transaction outstanding |

## Verification
The assertions check the following on every cycle:
- a locked data read yields 0xFF;
- an idle trigger read or a magic-value trigger write raises a request in the right direction;
- a request never appears without a host access;
- the request holds steady until ready and then drops.

Only the bench scenarios can show the rest: the broken password sequence, relocking, per-device independence of the banks, byte ordering of the windows, return-word capture, and the protection of the windows while a transaction is stalled.

// File: rtl/cfgspace_pkg.sv
package cfgspace_pkg;
  typedef enum logic [1:0] {LK_SHUT, LK_HALF, LK_OPEN} lock_st_e;
  typedef enum logic [1:0] {SRC_GLOBAL, SRC_BANK, SRC_BRIDGE} rd_src_e;

  localparam logic [7:0] KEY_OPEN   = 8'hA5;
  localparam logic [7:0] KEY_SHUT   = 8'hAA;
  localparam logic [7:0] REG_DEVSEL = 8'h07;
  localparam logic [7:0] REG_SCR0   = 8'h21;
  localparam logic [7:0] REG_SCR1   = 8'h22;
  localparam logic [7:0] REG_ENABLE = 8'h30;
  localparam logic [7:0] REG_BASE0  = 8'h60;
  localparam logic [7:0] BR_WIN0    = 8'hF0;
  localparam logic [7:0] BR_TRIG    = 8'hFE;
  localparam logic [7:0] BR_MAGIC   = 8'hCF;
endpackage

// File: rtl/cfg_unlock.sv
module cfg_unlock
  import cfgspace_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       unlocked
);
  lock_st_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= LK_SHUT;
    end else if (idx_wr) begin
      case (st_q)
        LK_SHUT: st_q <= (wdata == KEY_OPEN) ? LK_HALF : LK_SHUT;
        LK_HALF: st_q <= (wdata == KEY_OPEN) ? LK_OPEN : LK_SHUT;
        LK_OPEN: if (wdata == KEY_SHUT) st_q <= LK_SHUT;
        default: st_q <= LK_SHUT;
      endcase
    end
  end

  assign unlocked = (st_q == LK_OPEN);
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
  import cfgspace_pkg::*;
#(
  parameter int NUM_DEV = 16,
  parameter int SLOT_W  = 3,
  parameter int DEV_W   = $clog2(NUM_DEV)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       acc_wr,
  input  logic       acc_rd,
  input  logic [7:0] dev,
  input  logic [7:0] regno,
  input  logic [7:0] wdata,
  output logic       hit,
  output logic [7:0] rdata
);
  localparam int SLOTS = 1 << SLOT_W;
  localparam int DEPTH = NUM_DEV * SLOTS;
  localparam int RAW   = DEV_W + SLOT_W;

  logic [7:0]        base_off;
  logic              is_en, is_base, dev_ok;
  logic [SLOT_W-1:0] slot;
  logic [RAW-1:0]    ram_addr;
  logic [NUM_DEV-1:0] en_vec;
  logic [7:0]        mem [DEPTH];
  logic [7:0]        ram_q;
  logic              en_rd_q, sel_en_q;

  assign base_off = regno - REG_BASE0;
  assign is_en    = (regno == REG_ENABLE);
  assign is_base  = (regno >= REG_BASE0) && (base_off < 8'(SLOTS - 1));
  assign dev_ok   = (dev < 8'(NUM_DEV));
  assign hit      = dev_ok && (is_en || is_base);
  assign slot     = is_base ? (base_off[SLOT_W-1:0] + SLOT_W'(1)) : '0;
  assign ram_addr = {dev[DEV_W-1:0], slot};

  // base-address bytes: plain single-port RAM, no reset
  always_ff @(posedge clk) begin
    if (acc_wr && hit && is_base) mem[ram_addr] <= wdata;
    if (acc_rd) ram_q <= mem[ram_addr];
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_en
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst) bit_q <= 1'b0;
      else if (acc_wr && hit && is_en && (dev[DEV_W-1:0] == DEV_W'(g)))
        bit_q <= wdata[0];
    end
    assign en_vec[g] = bit_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_rd_q  <= 1'b0;
      sel_en_q <= 1'b0;
    end else if (acc_rd) begin
      en_rd_q  <= en_vec[dev[DEV_W-1:0]];
      sel_en_q <= is_en;
    end
  end

  assign rdata = sel_en_q ? {7'b0, en_rd_q} : ram_q;
endmodule

// File: rtl/cfg_mem_bridge.sv
module cfg_mem_bridge
  import cfgspace_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_wr,
  input  logic          acc_rd,
  input  logic [7:0]    regno,
  input  logic [7:0]    wdata,
  output logic          hit,
  output logic [7:0]    rdata,
  output logic          m_req,
  output logic          m_we,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic          m_ready,
  input  logic [DW-1:0] m_rdata,
  output logic          busy
);
  localparam int NAB = AW / 8;
  localparam int NDB = DW / 8;
  localparam logic [7:0] DATA0  = BR_WIN0 + 8'(NAB);
  localparam logic [7:0] REG_LN = BR_WIN0 + 8'(NAB + NDB);

  logic [AW-1:0] addr_word;
  logic [DW-1:0] data_word;
  logic [7:0]    len_q, rd_mux, rd_q;
  logic          req_q, we_q, start_rd, start_wr, load_ok, done_rd;

  assign load_ok  = acc_wr && !req_q;
  assign done_rd  = req_q && m_ready && !we_q;
  assign start_rd = acc_rd && (regno == BR_TRIG) && !req_q;
  assign start_wr = acc_wr && (regno == BR_TRIG) && (wdata == BR_MAGIC) && !req_q;
  assign hit      = ((regno >= BR_WIN0) && (regno <= REG_LN)) || (regno == BR_TRIG);

  for (genvar i = 0; i < NAB; i++) begin : g_abyte
    localparam logic [7:0] RA = BR_WIN0 + 8'(i);
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (load_ok && regno == RA) q <= wdata;
    end
    assign addr_word[AW-1-8*i -: 8] = q;
  end

  for (genvar i = 0; i < NDB; i++) begin : g_dbyte
    localparam logic [7:0] RD = DATA0 + 8'(i);
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else if (done_rd) q <= m_rdata[DW-1-8*i -: 8];
      else if (load_ok && regno == RD) q <= wdata;
    end
    assign data_word[DW-1-8*i -: 8] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) len_q <= '0;
    else if (load_ok && regno == REG_LN) len_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      we_q  <= 1'b0;
    end else if (req_q && m_ready) begin
      req_q <= 1'b0;
    end else if (start_rd || start_wr) begin
      req_q <= 1'b1;
      we_q  <= start_wr;
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    for (int i = 0; i < NAB; i++)
      if (regno == BR_WIN0 + 8'(i)) rd_mux = addr_word[AW-1-8*i -: 8];
    for (int i = 0; i < NDB; i++)
      if (regno == DATA0 + 8'(i)) rd_mux = data_word[DW-1-8*i -: 8];
    if (regno == REG_LN)  rd_mux = len_q;
    if (regno == BR_TRIG) rd_mux = {7'b0, req_q};
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (acc_rd) rd_q <= rd_mux;
  end

  assign rdata   = rd_q;
  assign m_req   = req_q;
  assign m_we    = we_q;
  assign m_addr  = addr_word;
  assign m_wdata = data_word;
  assign busy    = req_q;
endmodule

// File: rtl/cfgspace_bridge.sv
module cfgspace_bridge
  import cfgspace_pkg::*;
#(
  parameter logic [7:0] INDEX_PORT = 8'h2E,
  parameter logic [7:0] DATA_PORT  = 8'h2F,
  parameter int         NUM_DEV    = 16,
  parameter int         SLOT_W     = 3,
  parameter logic [7:0] BRIDGE_DEV = 8'h0D,
  parameter int         BUS_AW     = 32,
  parameter int         BUS_DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              m_req,
  output logic              m_we,
  output logic [BUS_AW-1:0] m_addr,
  output logic [BUS_DW-1:0] m_wdata,
  input  logic              m_ready,
  input  logic [BUS_DW-1:0] m_rdata,
  output logic              bridge_busy
);
  logic       unlocked, idx_wr, data_wr, data_rd, br_sel;
  logic [7:0] index_q, devsel_q, scr0_q, scr1_q, glob_q;
  rd_src_e    src_q;
  logic       bank_hit, br_hit;
  logic [7:0] bank_rdata, br_rdata;

  assign idx_wr  = io_wr && (io_addr == INDEX_PORT);
  assign data_wr = io_wr && (io_addr == DATA_PORT) && unlocked;
  assign data_rd = io_rd && (io_addr == DATA_PORT) && unlocked;
  assign br_sel  = (devsel_q == BRIDGE_DEV);

  cfg_unlock u_lock (
    .clk      (clk),
    .rst      (rst),
    .idx_wr   (idx_wr),
    .wdata    (io_wdata),
    .unlocked (unlocked)
  );

  cfg_dev_bank #(.NUM_DEV(NUM_DEV), .SLOT_W(SLOT_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .acc_wr (data_wr),
    .acc_rd (data_rd),
    .dev    (devsel_q),
    .regno  (index_q),
    .wdata  (io_wdata),
    .hit    (bank_hit),
    .rdata  (bank_rdata)
  );

  cfg_mem_bridge #(.AW(BUS_AW), .DW(BUS_DW)) u_bridge (
    .clk     (clk),
    .rst     (rst),
    .acc_wr  (data_wr && br_sel),
    .acc_rd  (data_rd && br_sel),
    .regno   (index_q),
    .wdata   (io_wdata),
    .hit     (br_hit),
    .rdata   (br_rdata),
    .m_req   (m_req),
    .m_we    (m_we),
    .m_addr  (m_addr),
    .m_wdata (m_wdata),
    .m_ready (m_ready),
    .m_rdata (m_rdata),
    .busy    (bridge_busy)
  );

  // index register and global bytes
  always_ff @(posedge clk) begin
    if (rst) begin
      index_q  <= '0;
      devsel_q <= '0;
      scr0_q   <= '0;
      scr1_q   <= '0;
    end else begin
      if (idx_wr && unlocked && io_wdata != KEY_SHUT) index_q <= io_wdata;
      if (data_wr) begin
        case (index_q)
          REG_DEVSEL: devsel_q <= io_wdata;
          REG_SCR0:   scr0_q   <= io_wdata;
          REG_SCR1:   scr1_q   <= io_wdata;
          default: ;
        endcase
      end
    end
  end

  // read source selection, registered with the strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      glob_q <= 8'hFF;
      src_q  <= SRC_GLOBAL;
    end else if (io_rd) begin
      if (io_addr == INDEX_PORT) begin
        src_q  <= SRC_GLOBAL;
        glob_q <= unlocked ? index_q : 8'hFF;
      end else if (io_addr == DATA_PORT) begin
        src_q <= SRC_GLOBAL;
        if (!unlocked)                     glob_q <= 8'hFF;
        else if (index_q == REG_DEVSEL)    glob_q <= devsel_q;
        else if (index_q == REG_SCR0)      glob_q <= scr0_q;
        else if (index_q == REG_SCR1)      glob_q <= scr1_q;
        else if (bank_hit)                 src_q  <= SRC_BANK;
        else if (br_sel && br_hit)         src_q  <= SRC_BRIDGE;
        else                               glob_q <= 8'h00;
      end
    end
  end

  always_comb begin
    case (src_q)
      SRC_BANK:   io_rdata = bank_rdata;
      SRC_BRIDGE: io_rdata = br_rdata;
      default:    io_rdata = glob_q;
    endcase
  end
endmodule

// File: rtl/cfgspace_bridge_chk.sv
module cfgspace_bridge_chk #(
  parameter logic [7:0] INDEX_PORT = 8'h2E,
  parameter logic [7:0] DATA_PORT  = 8'h2F,
  parameter logic [7:0] BRIDGE_DEV = 8'h0D,
  parameter int         BUS_AW     = 32,
  parameter int         BUS_DW     = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              m_req,
  input logic              m_we,
  input logic [BUS_AW-1:0] m_addr,
  input logic [BUS_DW-1:0] m_wdata,
  input logic              m_ready,
  input logic              unlocked,
  input logic [7:0]        index_q,
  input logic [7:0]        devsel_q
);
  logic trig_ctx;
  assign trig_ctx = unlocked && (io_addr == DATA_PORT) && (devsel_q == BRIDGE_DEV)
                    && (index_q == 8'hFE) && !m_req;

  AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == DATA_PORT && !unlocked) |=> (io_rdata == 8'hFF)); // R2

  AST_READ_TRIGGER: assert property (@(posedge clk) disable iff (rst)
    (trig_ctx && io_rd) |=> (m_req && !m_we)); // R8

  AST_WRITE_TRIGGER: assert property (@(posedge clk) disable iff (rst)
    (trig_ctx && io_wr && io_wdata == 8'hCF) |=> (m_req && m_we)); // R10

  AST_NO_SPONTANEOUS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(m_req) |-> $past(io_rd || io_wr)); // R12

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_ready) |=> (m_req && $stable(m_we) && $stable(m_addr) && $stable(m_wdata))); // R9

  AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_ready) |=> !m_req); // R9
endmodule

bind cfgspace_bridge cfgspace_bridge_chk #(
  .INDEX_PORT (INDEX_PORT),
  .DATA_PORT  (DATA_PORT),
  .BRIDGE_DEV (BRIDGE_DEV),
  .BUS_AW     (BUS_AW),
  .BUS_DW     (BUS_DW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .io_addr  (io_addr),
  .io_rd    (io_rd),
  .io_wr    (io_wr),
  .io_wdata (io_wdata),
  .io_rdata (io_rdata),
  .m_req    (m_req),
  .m_we     (m_we),
  .m_addr   (m_addr),
  .m_wdata  (m_wdata),
  .m_ready  (m_ready),
  .unlocked (unlocked),
  .index_q  (index_q),
  .devsel_q (devsel_q)
);

// File: tb/tb_cfgspace_bridge.sv
module tb_cfgspace_bridge;
  localparam logic [7:0] IDX = 8'h2E;
  localparam logic [7:0] DAT = 8'h2F;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  io_addr = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        m_req, m_we, m_ready = 1'b0, bridge_busy;
  logic [31:0] m_addr, m_wdata, m_rdata = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit stall = 1'b0;
  int log_cnt = 0;
  logic        log_we;
  logic [31:0] log_addr, log_data;

  always #10 clk = ~clk;

  cfgspace_bridge dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .m_req(m_req), .m_we(m_we),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata),
    .bridge_busy(bridge_busy)
  );

  function automatic logic [31:0] bus_pattern(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'hC3A5_0F1E;
  endfunction

  // memory-bus slave: random ready delay, logs each accepted transaction
  always @(negedge clk) begin
    m_ready = 1'b0;
    if (!rst && m_req && !stall && ($urandom % 3 == 0)) begin
      m_ready  = 1'b1;
      m_rdata  = bus_pattern(m_addr);
      log_cnt  = log_cnt + 1;
      log_we   = m_we;
      log_addr = m_addr;
      log_data = m_wdata;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic cfg_wr(input logic [7:0] r, input logic [7:0] d);
    io_write(IDX, r);
    io_write(DAT, d);
  endtask

  task automatic cfg_rd(input logic [7:0] r, output logic [7:0] d);
    io_write(IDX, r);
    io_read(DAT, d);
  endtask

  task automatic wait_idle();
    while (bridge_busy) @(negedge clk);
  endtask

  task automatic load_word(input logic [7:0] base, input logic [31:0] w);
    for (int i = 0; i < 4; i++) cfg_wr(base + 8'(i), w[31-8*i -: 8]);
  endtask

  task automatic read_word(input logic [7:0] base, output logic [31:0] w);
    logic [7:0] b;
    for (int i = 0; i < 4; i++) begin
      cfg_rd(base + 8'(i), b);
      w[31-8*i -: 8] = b;
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  logic [7:0]  bmodel [16][8];
  bit          bvalid [16][8];
  bit          emodel [16];

  initial begin
    logic [7:0]  rb, prev;
    logic [31:0] w, cnt0;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 rdata", io_rdata, 8'hFF);
    check("R1 m_req", m_req, 0);
    // R2 locked: reads FF, writes ignored, broken sequence stays locked
    cfg_rd(8'h07, rb);            check("R2 locked read", rb, 8'hFF);
    cfg_wr(8'h21, 8'h55);
    io_write(IDX, 8'hA5); io_write(IDX, 8'h21); io_write(IDX, 8'hA5);
    io_read(DAT, rb);             check("R2 broken sequence", rb, 8'hFF);
    io_write(IDX, 8'hA5); io_write(IDX, 8'hA5);
    cfg_rd(8'h21, rb);            check("R2 locked write ignored", rb, 8'h00);
    cfg_rd(8'h07, rb);            check("R1 devsel reset", rb, 8'h00);
    cfg_rd(8'h30, rb);            check("R1 enable reset", rb, 8'h00);

    // R4 scratch
    cfg_wr(8'h21, 8'h3C); cfg_wr(8'h22, 8'hC3);
    cfg_rd(8'h21, rb);            check("R4 scratch0", rb, 8'h3C);
    cfg_rd(8'h22, rb);            check("R4 scratch1", rb, 8'hC3);
    // R13 index readback, foreign addresses ignored
    io_read(IDX, rb);             check("R13 index readback", rb, 8'h22);
    io_read(8'h80, rb);           check("R13 foreign read holds", rb, 8'h22);
    io_write(8'h80, 8'h21);
    io_read(DAT, rb);             check("R13 foreign write ignored", rb, 8'hC3);

    // R5 R6 per-device banks
    cfg_wr(8'h07, 8'h05); cfg_wr(8'h30, 8'hFF); cfg_wr(8'h60, 8'hAA);
    cfg_wr(8'h07, 8'h0E); cfg_wr(8'h60, 8'h05); cfg_wr(8'h66, 8'h77);
    cfg_rd(8'h60, rb);            check("R6 dev0E base", rb, 8'h05);
    cfg_rd(8'h66, rb);            check("R6 dev0E last base", rb, 8'h77);
    cfg_rd(8'h30, rb);            check("R6 dev0E enable", rb, 8'h00);
    cfg_wr(8'h07, 8'h05);
    cfg_rd(8'h60, rb);            check("R5 dev05 base", rb, 8'hAA);
    cfg_rd(8'h30, rb);            check("R6 enable bit0", rb, 8'h01);

    // R3 relock, selection persists
    io_write(IDX, 8'hAA);
    io_read(DAT, rb);             check("R3 relocked", rb, 8'hFF);
    io_write(IDX, 8'hA5); io_write(IDX, 8'hA5);
    cfg_rd(8'h07, rb);            check("R3 devsel persists", rb, 8'h05);

    // R12 trigger in a non-bridge device
    cfg_wr(8'h07, 8'h03);
    cfg_rd(8'hFE, rb);            check("R12 trig read other dev", rb, 8'h00);
    check("R12 no req on read", m_req, 0);
    cfg_wr(8'hFE, 8'hCF);
    check("R12 no req on write", m_req, 0);
    cfg_rd(8'hF0, rb);            check("R12 window absent", rb, 8'h00);

    // R7 windows
    cfg_wr(8'h07, 8'h0D);
    load_word(8'hF0, 32'h1234_5678);
    load_word(8'hF4, 32'hDEAD_BEEF);
    cfg_wr(8'hF8, 8'h02);
    cfg_rd(8'hF0, rb);            check("R7 addr msb", rb, 8'h12);
    cfg_rd(8'hF3, rb);            check("R7 addr lsb", rb, 8'h78);
    cfg_rd(8'hF8, rb);            check("R7 length", rb, 8'h02);
    check("R7 m_addr order", m_addr, 32'h1234_5678);

    // R10 write trigger
    cfg_wr(8'hFE, 8'h00);
    check("R10 non-magic no req", m_req, 0);
    cnt0 = log_cnt;
    cfg_wr(8'hFE, 8'hCF);
    check("R10 req raised", m_req, 1);
    check("R10 direction", m_we, 1);
    check("R10 data", m_wdata, 32'hDEAD_BEEF);
    wait_idle();
    check("R10 one transfer", log_cnt - cnt0, 1);
    check("R10 logged addr", log_addr, 32'h1234_5678);

    // R8 R9 read trigger
    load_word(8'hF0, 32'hA0B0_C0D0);
    cnt0 = log_cnt;
    cfg_rd(8'hFE, rb);            check("R8 trig read value", rb, 8'h00);
    check("R8 read direction", m_we, 0);
    wait_idle();
    check("R9 one transfer", log_cnt - cnt0, 1);
    read_word(8'hF4, w);          check("R9 captured word", w, bus_pattern(32'hA0B0_C0D0));

    // R11 busy protection with stalled slave
    stall = 1'b1;
    load_word(8'hF0, 32'h0000_1000);
    cfg_rd(8'hF4, prev);
    cnt0 = log_cnt;
    cfg_rd(8'hFE, rb);
    cfg_wr(8'hF4, 8'h99);
    cfg_rd(8'hF4, rb);            check("R11 data held", rb, prev);
    cfg_wr(8'hF0, 8'hEE);
    cfg_rd(8'hFE, rb);            check("R8 busy status", rb, 8'h01);
    cfg_wr(8'hFE, 8'hCF);
    check("R11 direction held", m_we, 0);
    check("R11 addr held", m_addr, 32'h0000_1000);
    stall = 1'b0;
    wait_idle();
    check("R11 single transfer", log_cnt - cnt0, 1);
    cfg_rd(8'hF0, rb);            check("R11 addr write ignored", rb, 8'h00);

    // random bank traffic against a model
    for (int d = 0; d < 16; d++) begin
      emodel[d] = 1'b0;
      for (int s = 0; s < 8; s++) bvalid[d][s] = 1'b0;
      cfg_wr(8'h07, 8'(d)); cfg_wr(8'h30, 8'h00);
    end
    for (int k = 0; k < 120; k++) begin
      int d, s;
      logic [7:0] r, v;
      d = $urandom % 16; s = $urandom % 8;
      r = (s == 0) ? 8'h30 : 8'h60 + 8'(s - 1);
      v = 8'($urandom);
      cfg_wr(8'h07, 8'(d));
      if ($urandom % 2) begin
        cfg_wr(r, v);
        if (s == 0) emodel[d] = v[0];
        else begin bmodel[d][s] = v; bvalid[d][s] = 1'b1; end
      end else begin
        cfg_rd(r, rb);
        if (s == 0) check("R6 random enable", rb, {7'b0, emodel[d]});
        else if (bvalid[d][s]) check("R6 random base", rb, bmodel[d][s]);
      end
    end

    // random bridge traffic
    cfg_wr(8'h07, 8'h0D);
    for (int k = 0; k < 30; k++) begin
      logic [31:0] a, dd;
      a = $urandom; dd = $urandom;
      load_word(8'hF0, a);
      cnt0 = log_cnt;
      if ($urandom % 2) begin
        load_word(8'hF4, dd);
        cfg_wr(8'hFE, 8'hCF);
        wait_idle();
        check("R10 random write count", log_cnt - cnt0, 1);
        check("R10 random write addr", log_addr, a);
        check("R10 random write data", log_data, dd);
        check("R10 random write dir", log_we, 1);
      end else begin
        cfg_rd(8'hFE, rb);
        wait_idle();
        check("R8 random read addr", log_addr, a);
        check("R8 random read dir", log_we, 0);
        read_word(8'hF4, w);
        check("R9 random read word", w, bus_pattern(a));
      end
    end

    report();
  end
endmodule